// File: doc/BRIEF.md
# Level-Triggered Interrupt Router with Claim/Complete

This block takes level interrupt requests from a parameterized set of sources and routes them to a small number of targets, such as processor cores. Each source has a 2-bit priority. Each source also has one enable bit per target, and each target has a 2-bit threshold. A per-source gateway turns a request into a pending bit. It then holds that source off from the moment it is claimed until its service is reported finished. Identifier 0 means "nothing" and is never a real source. Real sources are numbered 1 to NumSrc-1.

Software talks to the block through a simple synchronous word port. Writes take effect on the clock edge. Read data is combinational from the current state.

The register index sits in the low address bits and the region in the top three bits:

| Region | Address (defaults) | Contents |
|---|---|---|
| 0 | s | priority of source s |
| 1 | 8 | pending vector |
| 2 | 16+t | enable mask of target t |
| 3 | 24+t | threshold of target t |
| 4 | 32+t | claim/complete register of target t |

Reading a target's claim/complete register takes the best qualifying source for that target. Writing a source ID back to it ends that source's service. Claims may nest, and completions may come back in any order.

Top module: `plic_core`

## Requirements
- R1: After reset the following are all zero: every pending bit, every in-service lock, priority, enable mask, threshold and `irqOut` bit. Every claim read returns 0.
- R2: Address s (1..NumSrc-1) holds the 2-bit priority of source s and reads back the low 2 bits written. Address 0 always reads 0 and ignores writes.
- R3: A high `irqSrc[s]` on an unlocked, non-pending source sets pending bit s at the next edge. The bit stays set after the input drops. The pending vector reads at address 8, with bit s standing for source s.
- R4: Source s qualifies for target t only when all three hold: it is pending, bit s of the enable mask at address 16+t is set, and its priority is strictly greater than the threshold at address 24+t. A priority of 0 never qualifies, and a threshold of 3 blocks everything.
- R5: `irqOut[t]` is registered. It goes high one edge after some source qualifies for target t, and goes low one edge after none does.
- R6: Among qualifying sources, the highest priority wins. On equal priority, the lowest source ID wins.
- R7: A read of address 32+t returns the winning ID for target t, or 0 if none. When a winner exists, the read clears its pending bit and sets its in-service lock at that edge. The pending bit is shared, so the source is then pending for no target.
- R8: While a source is locked, it does not become pending again and cannot be claimed, even if its input stays high.
- R9: Writing an in-service ID to any claim/complete register releases that lock. If the input is still high, the source becomes pending one edge later. A written ID that is not in service changes nothing.
- R10: Other sources can be claimed while earlier claims are still outstanding. Completions may arrive in any order, and each one frees only its own source.
- R11: Enable masks and thresholds act separately per target. A source can interrupt one target while being blocked for another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqSrc | input | NumSrc-1 | Level requests, bit s is source s (s >= 1) |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (claim side effect) |
| regAddr | input | AddrW | Word address |
| regWdata | input | DataW | Write data |
| regRdata | output | DataW | Read data, valid while regRe is high |
| irqOut | output | NumTgt | Registered interrupt line per target |

## Verification
Arbitration is driven from a vector table that covers six situations:
- equal priorities, which isolates the ID tie-break;
- one raised priority, which shows priority outranks ID;
- a masked winner, which shows the enable mask counts;
- thresholds just below and at a priority, which separate strict from non-strict comparison;
- all-zero priorities;
- a tie between non-adjacent sources.

Directed sequences hold two inputs high and then claim repeatedly. A claim of 0 shows that the locks, and not the inputs, gate delivery. Completing the first-claimed source before the second separates out-of-order release from stack-ordered release. A stray completion must leave the locks unchanged. Different settings on the two targets show that their masks and thresholds do not share state.

// File: rtl/plic_pkg.sv
package plic_pkg;

  localparam int IdxBits = 8;

  localparam logic [2:0] RegionPrio  = 3'd0;
  localparam logic [2:0] RegionPend  = 3'd1;
  localparam logic [2:0] RegionEn    = 3'd2;
  localparam logic [2:0] RegionThr   = 3'd3;
  localparam logic [2:0] RegionClaim = 3'd4;

  typedef enum logic [2:0] {
    RdNone  = 3'd0,
    RdPrio  = 3'd1,
    RdPend  = 3'd2,
    RdEn    = 3'd3,
    RdThr   = 3'd4,
    RdClaim = 3'd5
  } rdSel_t;

  typedef struct packed {
    logic               prioWr;
    logic               enWr;
    logic               thrWr;
    logic               claimRd;
    logic               complWr;
    rdSel_t             rdSel;
    logic [IdxBits-1:0] idx;
  } ctlStrobe_t;

endpackage

// File: rtl/plic_ctrl.sv
module plic_ctrl
  import plic_pkg::*;
#(
  parameter int NumSrc = 8,
  parameter int NumTgt = 2,
  parameter int AddrW  = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic             regRe,
  input  logic [AddrW-1:0] regAddr,
  output ctlStrobe_t       ctl
);

  localparam int IdxW = AddrW - 3;
  localparam logic [IdxW:0] SrcLim = (IdxW + 1)'(NumSrc);
  localparam logic [IdxW:0] TgtLim = (IdxW + 1)'(NumTgt);

  logic [2:0]      region;
  logic [IdxW-1:0] idxRaw;
  logic            srcOk;
  logic            tgtOk;
  logic            rdOnly;

  assign region = regAddr[AddrW-1 -: 3];
  assign idxRaw = regAddr[IdxW-1:0];
  assign srcOk  = (idxRaw != '0) && ({1'b0, idxRaw} < SrcLim);
  assign tgtOk  = {1'b0, idxRaw} < TgtLim;
  assign rdOnly = regRe && !regWe;

  always_comb begin
    ctl         = '0;
    ctl.rdSel   = RdNone;
    ctl.idx     = {{(IdxBits - IdxW){1'b0}}, idxRaw};
    case (region)
      RegionPrio: begin
        ctl.prioWr = regWe && srcOk;
        if (rdOnly && srcOk) ctl.rdSel = RdPrio;
      end
      RegionPend: begin
        if (rdOnly) ctl.rdSel = RdPend;
      end
      RegionEn: begin
        ctl.enWr = regWe && tgtOk;
        if (rdOnly && tgtOk) ctl.rdSel = RdEn;
      end
      RegionThr: begin
        ctl.thrWr = regWe && tgtOk;
        if (rdOnly && tgtOk) ctl.rdSel = RdThr;
      end
      RegionClaim: begin
        ctl.complWr = regWe && tgtOk;
        ctl.claimRd = rdOnly && tgtOk;
        if (rdOnly && tgtOk) ctl.rdSel = RdClaim;
      end
      default: ;
    endcase
  end

  // R7: a single access never raises two datapath operations at once
  p_one_access_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.prioWr, ctl.enWr, ctl.thrWr, ctl.claimRd, ctl.complWr}));

  // R7: a claim strobe only ever comes from a read
  p_claim_is_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.claimRd |-> (regRe && !regWe));

endmodule

// File: rtl/plic_arbiter.sv
module plic_arbiter #(
  parameter int NumSrc = 8,
  parameter int PrioW  = 2,
  localparam int SrcW  = $clog2(NumSrc)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NumSrc-1:0]              qual,
  input  logic [NumSrc-1:0][PrioW-1:0]   prio,
  output logic [SrcW-1:0]                winId,
  output logic                           anyQual
);

  logic [PrioW-1:0] bestPrio;

  // Ascending scan with a strict compare keeps the lowest ID on ties.
  always_comb begin
    winId    = '0;
    bestPrio = '0;
    anyQual  = 1'b0;
    for (int s = 0; s < NumSrc; s++) begin
      if (qual[s] && (!anyQual || (prio[s] > bestPrio))) begin
        winId    = SrcW'(s);
        bestPrio = prio[s];
        anyQual  = 1'b1;
      end
    end
  end

  // R6: a reported winner is itself a qualifying source
  p_win_qualifies_r6: assert property (@(posedge clk) disable iff (!rstN)
    anyQual |-> qual[winId]);

  for (genvar gs = 0; gs < NumSrc; gs++) begin : g_chk
    // R6: no qualifying source outranks the winner
    p_win_highest_r6: assert property (@(posedge clk) disable iff (!rstN)
      (anyQual && qual[gs]) |-> (prio[winId] >= prio[gs]));
    // R6: equal priority resolves to the lowest ID
    p_tie_lowest_r6: assert property (@(posedge clk) disable iff (!rstN)
      (anyQual && qual[gs] && (prio[gs] == prio[winId])) |-> (winId <= SrcW'(gs)));
  end

endmodule

// File: rtl/plic_datapath.sv
module plic_datapath
  import plic_pkg::*;
#(
  parameter int NumSrc = 8,
  parameter int NumTgt = 2,
  parameter int PrioW  = 2,
  parameter int DataW  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NumSrc-1:1] irqSrc,
  input  ctlStrobe_t        ctl,
  input  logic [DataW-1:0]  wdata,
  output logic [DataW-1:0]  rdata,
  output logic [NumTgt-1:0] irqOut
);

  localparam int SrcW = $clog2(NumSrc);
  localparam int TgtW = (NumTgt > 1) ? $clog2(NumTgt) : 1;

  logic [NumSrc-1:0][PrioW-1:0]  prio;
  logic [NumTgt-1:0][NumSrc-1:0] en;
  logic [NumTgt-1:0][PrioW-1:0]  thr;
  logic [NumSrc-1:0]             pending;
  logic [NumSrc-1:0]             inSvc;
  logic [NumTgt-1:0][NumSrc-1:0] qual;
  logic [NumTgt-1:0][SrcW-1:0]   winId;
  logic [NumTgt-1:0]             anyQual;

  logic [SrcW-1:0] idxS;
  logic [TgtW-1:0] idxT;
  logic            idxHiZero;
  logic [SrcW-1:0] claimWin;
  logic            claimFire;
  logic [SrcW-1:0] complId;
  logic            complHit;

  assign idxS      = ctl.idx[SrcW-1:0];
  assign idxT      = ctl.idx[TgtW-1:0];
  assign idxHiZero = (ctl.idx[IdxBits-1:SrcW] == '0);
  assign claimWin  = winId[idxT];
  assign claimFire = ctl.claimRd && idxHiZero && (claimWin != '0);
  assign complId   = wdata[SrcW-1:0];
  assign complHit  = ctl.complWr && (wdata[DataW-1:SrcW] == '0) && inSvc[complId];

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prio <= '0;
      en   <= '0;
      thr  <= '0;
    end else begin
      if (ctl.prioWr && idxHiZero) prio[idxS] <= wdata[PrioW-1:0];
      if (ctl.enWr && idxHiZero)   en[idxT]   <= wdata[NumSrc-1:0] & ~NumSrc'(1);
      if (ctl.thrWr && idxHiZero)  thr[idxT]  <= wdata[PrioW-1:0];
    end
  end

  // Gateways: latch a level request, lock from claim until completion
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= '0;
      inSvc   <= '0;
    end else begin
      for (int s = 1; s < NumSrc; s++) begin
        if (claimFire && (claimWin == SrcW'(s))) begin
          pending[s] <= 1'b0;
          inSvc[s]   <= 1'b1;
        end else begin
          if (complHit && (complId == SrcW'(s))) inSvc[s] <= 1'b0;
          if (irqSrc[s] && !pending[s] && !inSvc[s]) pending[s] <= 1'b1;
        end
      end
    end
  end

  // Per-target qualification and arbitration
  for (genvar gt = 0; gt < NumTgt; gt++) begin : g_tgt
    always_comb begin
      for (int s = 0; s < NumSrc; s++) begin
        qual[gt][s] = pending[s] && en[gt][s] && (prio[s] > thr[gt]);
      end
    end

    plic_arbiter #(
      .NumSrc(NumSrc),
      .PrioW (PrioW)
    ) u_arb (
      .clk    (clk),
      .rstN   (rstN),
      .qual   (qual[gt]),
      .prio   (prio),
      .winId  (winId[gt]),
      .anyQual(anyQual[gt])
    );

    // R5: the line follows qualification after exactly one edge
    p_irq_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
      anyQual[gt] |=> irqOut[gt]);
    p_irq_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
      !anyQual[gt] |=> !irqOut[gt]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= '0;
    else       irqOut <= anyQual;
  end

  // Readback
  always_comb begin
    case (ctl.rdSel)
      RdPrio:  rdata = DataW'(prio[idxS]);
      RdPend:  rdata = DataW'(pending);
      RdEn:    rdata = DataW'(en[idxT]);
      RdThr:   rdata = DataW'(thr[idxT]);
      RdClaim: rdata = DataW'(claimWin);
      default: rdata = '0;
    endcase
  end

  for (genvar gs = 1; gs < NumSrc; gs++) begin : g_src_chk
    // R7: a claim takes the source out of pending and into service
    p_claim_locks_r7: assert property (@(posedge clk) disable iff (!rstN)
      (claimFire && (claimWin == SrcW'(gs))) |=> (inSvc[gs] && !pending[gs]));
    // R8: a locked source is never pending
    p_lock_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
      inSvc[gs] |-> !pending[gs]);
    // R9: only a matching completion ends service
    p_lock_holds_r9: assert property (@(posedge clk) disable iff (!rstN)
      (inSvc[gs] && !(ctl.complWr && (wdata == DataW'(gs)))) |=> inSvc[gs]);
    // R9: a matching completion frees the source
    p_complete_frees_r9: assert property (@(posedge clk) disable iff (!rstN)
      (complHit && (complId == SrcW'(gs))) |=> !inSvc[gs]);
  end

endmodule

// File: rtl/plic_core.sv
module plic_core
  import plic_pkg::*;
#(
  parameter int NumSrc = 8,
  parameter int NumTgt = 2,
  parameter int PrioW  = 2,
  parameter int AddrW  = 6,
  parameter int DataW  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NumSrc-1:1] irqSrc,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [AddrW-1:0]  regAddr,
  input  logic [DataW-1:0]  regWdata,
  output logic [DataW-1:0]  regRdata,
  output logic [NumTgt-1:0] irqOut
);

  ctlStrobe_t ctl;

  plic_ctrl #(
    .NumSrc(NumSrc),
    .NumTgt(NumTgt),
    .AddrW (AddrW)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .regWe  (regWe),
    .regRe  (regRe),
    .regAddr(regAddr),
    .ctl    (ctl)
  );

  plic_datapath #(
    .NumSrc(NumSrc),
    .NumTgt(NumTgt),
    .PrioW (PrioW),
    .DataW (DataW)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .irqSrc(irqSrc),
    .ctl   (ctl),
    .wdata (regWdata),
    .rdata (regRdata),
    .irqOut(irqOut)
  );

endmodule

// File: tb/sim_plic_core.sv
module sim_plic_core;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:1]  irqSrc = '0;
  logic        regWe = 1'b0;
  logic        regRe = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [1:0]  irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  plic_core u0 (
    .clk     (clk),
    .rstN    (rstN),
    .irqSrc  (irqSrc),
    .regWe   (regWe),
    .regRe   (regRe),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .irqOut  (irqOut)
  );

  typedef struct packed {
    logic [13:0] prio;
    logic [7:0]  en;
    logic [1:0]  thr;
    logic [7:0]  src;
    logic [2:0]  expId;
  } vec_t;

  localparam vec_t Vecs [0:8] = '{
    '{14'h1555, 8'hFE, 2'd0, 8'h0A, 3'd1},
    '{14'h1575, 8'hFE, 2'd0, 8'h0A, 3'd3},
    '{14'h1575, 8'hF6, 2'd0, 8'h0A, 3'd1},
    '{14'h1575, 8'hFE, 2'd1, 8'h0A, 3'd3},
    '{14'h1575, 8'hFE, 2'd1, 8'h02, 3'd0},
    '{14'h3FFF, 8'hFE, 2'd3, 8'hFE, 3'd0},
    '{14'h3FFF, 8'hFE, 2'd2, 8'hC0, 3'd6},
    '{14'h0000, 8'hFE, 2'd0, 8'hFE, 3'd0},
    '{14'h2008, 8'hFE, 2'd0, 8'h84, 3'd2}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    regRe = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRe = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0; irqSrc = '0; regWe = 1'b0; regRe = 1'b0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    #(8 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    doReset();

    // R1: reset state
    check("R1 irqOut", 32'(irqOut), 0);
    rd(6'd8, v);  check("R1 pending", v, 0);
    rd(6'd32, v); check("R1 claim t0", v, 0);
    rd(6'd33, v); check("R1 claim t1", v, 0);
    rd(6'd3, v);  check("R1 prio", v, 0);
    rd(6'd24, v); check("R1 thr", v, 0);
    rd(6'd16, v); check("R1 enable", v, 0);

    // R2: priority registers
    wr(6'd3, 32'd2);    rd(6'd3, v); check("R2 prio3", v, 2);
    wr(6'd5, 32'hFF);   rd(6'd5, v); check("R2 prio5 width", v, 3);
    wr(6'd0, 32'd3);    rd(6'd0, v); check("R2 prio0", v, 0);

    // setup: prio2=3, prio5=2, prio3=1; target0 enables 2,3,5
    wr(6'd2, 32'd3); wr(6'd5, 32'd2); wr(6'd3, 32'd1);
    wr(6'd16, 32'h2C); wr(6'd17, 32'h00);

    // R3/R5: latch and registered line
    irqSrc[3] = 1'b1;
    @(negedge clk);
    check("R5 irq not yet", 32'(irqOut[0]), 0);
    irqSrc[3] = 1'b0;
    rd(6'd8, v); check("R3 pending latched", v, 32'h08);
    check("R5 irq high", 32'(irqOut[0]), 1);
    check("R11 t1 line", 32'(irqOut[1]), 0);
    rd(6'd33, v); check("R11 t1 claim none", v, 0);

    // R7: claim
    rd(6'd32, v); check("R7 claim id", v, 3);
    rd(6'd8, v);  check("R7 pending cleared", v, 0);
    check("R7 line drops", 32'(irqOut[0]), 0);
    wr(6'd32, 32'd3);

    // R6/R8/R10: nesting with held inputs
    irqSrc[2] = 1'b1; irqSrc[5] = 1'b1;
    @(negedge clk);
    rd(6'd32, v); check("R6 higher prio first", v, 2);
    rd(6'd32, v); check("R10 nested claim", v, 5);
    rd(6'd32, v); check("R8 both locked", v, 0);
    rd(6'd8, v);  check("R8 no re-pend", v, 0);

    // R9: stray completions
    wr(6'd32, 32'd3); wr(6'd32, 32'd0);
    @(negedge clk);
    rd(6'd8, v);  check("R9 stray ignored pend", v, 0);
    rd(6'd32, v); check("R9 stray ignored claim", v, 0);

    // R10: complete the first claim before the second
    wr(6'd32, 32'd2);
    @(negedge clk);
    rd(6'd8, v);  check("R9 re-pend after complete", v, 32'h04);
    rd(6'd32, v); check("R10 out of order reclaim", v, 2);
    wr(6'd32, 32'd5);
    @(negedge clk);
    rd(6'd8, v);  check("R10 second freed", v, 32'h20);
    rd(6'd32, v); check("R10 reclaim 5", v, 5);
    irqSrc = '0;
    wr(6'd32, 32'd2); wr(6'd32, 32'd5);

    // R11: per-target enable and threshold
    wr(6'd17, 32'h20); wr(6'd25, 32'd2);
    irqSrc[5] = 1'b1;
    @(negedge clk); @(negedge clk);
    irqSrc[5] = 1'b0;
    check("R11 t0 line", 32'(irqOut[0]), 1);
    check("R4 t1 thr equal blocks", 32'(irqOut[1]), 0);
    rd(6'd33, v); check("R4 t1 claim blocked", v, 0);
    wr(6'd25, 32'd1);
    @(negedge clk);
    check("R11 t1 line after thr", 32'(irqOut[1]), 1);
    rd(6'd33, v); check("R11 t1 claim", v, 5);
    rd(6'd32, v); check("R7 shared pending", v, 0);

    // R4/R6: arbitration table
    for (int i = 0; i < 9; i++) begin
      doReset();
      for (int s = 1; s < 8; s++) wr(6'(s), 32'(Vecs[i].prio[2*(s-1) +: 2]));
      wr(6'd16, 32'(Vecs[i].en));
      wr(6'd24, 32'(Vecs[i].thr));
      irqSrc = Vecs[i].src[7:1];
      @(negedge clk); @(negedge clk);
      check($sformatf("R4/R6 vec%0d line", i), 32'(irqOut[0]), 32'(Vecs[i].expId != 0));
      rd(6'd32, v);
      check($sformatf("R4/R6 vec%0d claim", i), v, 32'(Vecs[i].expId));
      irqSrc = '0;
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule